// File: doc/BRIEF.md
# UART Bit-Rate and Receive-Timeout Generator

This block turns a reference clock into the two timing strobes a serial transmitter and receiver need. A sample strobe comes out of an optional divide-by-8 prescaler followed by a 16-bit clock divisor. A bit strobe marks every (per-bit divisor + 1)-th sample strobe, so the bit rate is the selected clock divided by `cd * (bdiv + 1)`. Divisor writes carry a wide data word; only the low bits are kept. A write that would give an unusable divisor is dropped, and the previous value stays in force.

The block also decodes the mode byte (prescaler select, character length, parity, stop bits) into the number of bit periods in one frame. It runs a receive-timeout timer, which a received-byte strobe re-arms. The timer expires after a fixed number of character times, counted in bit strobes. Expiry gives a one-cycle pulse meant for the interrupt logic's timeout event.

There is no data stream at this block's edge. Every pin is a plain control or status level or strobe, with no valid/ready handshake and no back-pressure. Strobes are one clock wide and the consumer must act in that cycle.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the clock divisor reads 0x28B, the per-bit divisor reads 0x0F and the timeout pulse is low.
- R2: An accepted clock-divisor write keeps only data bits 15:0, and an accepted per-bit-divisor write keeps only data bits 7:0. The new value shows on the divisor outputs in the cycle after the write strobe.
- R3: A clock-divisor write whose bits 15:0 are zero is ignored. A per-bit-divisor write whose bits 7:0 are below 4 is ignored. A value of 4 is accepted.
- R4: With mode bit 0 low, the sample strobe repeats every `cd` clocks. With mode bit 0 high, it repeats every `8*cd` clocks.
- R5: The bit strobe is asserted only together with a sample strobe, once every `bdiv+1` sample strobes, so it repeats every `cd*(bdiv+1)` clocks when the prescaler is off.
- R6: Character length, mode bits 2:1: 3 gives 6 data bits, 2 gives 7, and 0 or 1 gives 8. The frame length is 1 + data bits + parity bits + stop bits.
- R7: Parity, mode bits 5:3: values 0 (even), 1 (odd), 2 and 3 add one parity bit. Values 4 to 7 add none.
- R8: Stop bits, mode bits 7:6: 2 gives 2 stop bits. Any other value (3 included) gives 1.
- R9: After a received-byte strobe, the timeout pulse rises for exactly one clock, in the cycle after the `4*frame`-th bit strobe that follows the strobe's clock edge.
- R10: A received-byte strobe while the timer is running restarts the full `4*frame` count. No pulse is issued for the earlier byte.
- R11: An accepted divisor write clears the tick counters. With the prescaler off, the first sample strobe comes in the `cd`-th cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 8 | Mode byte: [0] prescale, [2:1] length, [5:3] parity, [7:6] stop |
| cd_wr_i | input | 1 | Clock-divisor write strobe |
| bdiv_wr_i | input | 1 | Per-bit-divisor write strobe |
| wdata_i | input | 32 | Write data for both divisor strobes |
| rx_byte_i | input | 1 | One-cycle strobe per received byte |
| sample_tick_o | output | 1 | Sample strobe |
| bit_tick_o | output | 1 | Bit strobe |
| frame_bits_o | output | 4 | Bit periods per frame |
| timeout_o | output | 1 | One-cycle receive-timeout pulse |
| cd_o | output | 16 | Clock divisor in force |
| bdiv_o | output | 8 | Per-bit divisor in force |

## Verification
A counter that skips or overruns a value shows up at once as a wrong spacing between sample or bit strobes, within one bit period, so the bench measures intervals in whole clocks. A divisor register that takes an invalid write shows on the divisor outputs in the next cycle. A bad timeout count shows up only after four character times, as a pulse one or more bit periods early or late, or missing. For that reason the bench counts bit strobes exactly and checks that the pulse stays low before the expected cycle and low again after it.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

  localparam int CD_W     = 16;
  localparam int BDIV_W   = 8;
  localparam int FRAME_W  = 4;
  localparam int MAX_FRAME = 12;

  typedef struct packed {
    logic [1:0] stop_sel;
    logic [2:0] par_sel;
    logic [1:0] len_sel;
    logic       pre_en;
  } mode_t;

  function automatic logic [FRAME_W-1:0] data_bits(input logic [1:0] sel);
    case (sel)
      2'd3:    data_bits = FRAME_W'(6);
      2'd2:    data_bits = FRAME_W'(7);
      default: data_bits = FRAME_W'(8);
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] parity_bits(input logic [2:0] sel);
    case (sel)
      3'd0, 3'd1, 3'd2, 3'd3: parity_bits = FRAME_W'(1);
      default:                parity_bits = FRAME_W'(0);
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] stop_bits(input logic [1:0] sel);
    stop_bits = (sel == 2'd2) ? FRAME_W'(2) : FRAME_W'(1);
  endfunction

endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int                WR_W     = 32,
  parameter int                CD_W     = 16,
  parameter int                BDIV_W   = 8,
  parameter logic [CD_W-1:0]   CD_RST   = 16'h028B,
  parameter logic [BDIV_W-1:0] BDIV_RST = 8'h0F,
  parameter int                BDIV_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cd_wr,
  input  logic              bdiv_wr,
  input  logic [WR_W-1:0]   wdata,
  output logic [CD_W-1:0]   cd_q,
  output logic [BDIV_W-1:0] bdiv_q,
  output logic              restart
);

  logic [CD_W-1:0]   cd_new;
  logic [BDIV_W-1:0] bdiv_new;
  logic              cd_ok;
  logic              bdiv_ok;
  logic              unused_hi;

  assign cd_new    = wdata[CD_W-1:0];
  assign bdiv_new  = wdata[BDIV_W-1:0];
  assign unused_hi = ^wdata[WR_W-1:CD_W];

  assign cd_ok   = cd_wr && (cd_new != '0);
  assign bdiv_ok = bdiv_wr && (bdiv_new >= BDIV_W'(BDIV_MIN));
  assign restart = cd_ok || bdiv_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cd_q   <= CD_RST;
      bdiv_q <= BDIV_RST;
    end else begin
      if (cd_ok)   cd_q   <= cd_new;
      if (bdiv_ok) bdiv_q <= bdiv_new;
    end
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int CD_W    = 16,
  parameter int BDIV_W  = 8,
  parameter int PRE_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_en,
  input  logic              restart,
  input  logic [CD_W-1:0]   cd,
  input  logic [BDIV_W-1:0] bdiv,
  output logic              sample_tick,
  output logic              bit_tick
);

  logic              clk_en;
  logic [CD_W-1:0]   cd_cnt;
  logic [BDIV_W-1:0] smp_cnt;
  logic              cd_last;
  logic              smp_last;

  generate
    if (PRE_DIV > 1) begin : g_pre
      localparam int PW = $clog2(PRE_DIV);
      logic [PW-1:0] pre_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || restart)
          pre_cnt <= '0;
        else if (pre_cnt == PW'(PRE_DIV - 1))
          pre_cnt <= '0;
        else
          pre_cnt <= pre_cnt + 1'b1;
      end
      assign clk_en = !pre_en || (pre_cnt == PW'(PRE_DIV - 1));
    end else begin : g_nopre
      logic unused_pre;
      assign unused_pre = pre_en;
      assign clk_en     = 1'b1;
    end
  endgenerate

  assign cd_last     = (cd_cnt == cd - 1'b1);
  assign sample_tick = clk_en && cd_last;
  assign smp_last    = (smp_cnt == bdiv);
  assign bit_tick    = sample_tick && smp_last;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      cd_cnt <= '0;
    else if (clk_en)
      cd_cnt <= cd_last ? '0 : cd_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      smp_cnt <= '0;
    else if (sample_tick)
      smp_cnt <= smp_last ? '0 : smp_cnt + 1'b1;
  end

endmodule

// File: rtl/frame_fmt_dec.sv
module frame_fmt_dec
  import uart_baud_pkg::*;
(
  input  mode_t              mode,
  output logic [FRAME_W-1:0] frame_bits
);

  assign frame_bits = FRAME_W'(1)
                    + data_bits(mode.len_sel)
                    + parity_bits(mode.par_sel)
                    + stop_bits(mode.stop_sel);

endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
  parameter int CHAR_TIMES = 4,
  parameter int FRAME_W    = 4,
  parameter int MAX_FRAME  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_byte,
  input  logic               bit_tick,
  input  logic [FRAME_W-1:0] frame_bits,
  output logic               expire
);

  localparam int CNT_W = $clog2(CHAR_TIMES * MAX_FRAME + 1);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] load_val;
  logic             armed;

  assign load_val = CNT_W'(CHAR_TIMES) * CNT_W'(frame_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      armed  <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (rx_byte) begin
        remain <= load_val;
        armed  <= 1'b1;
      end else if (armed && bit_tick) begin
        if (remain == CNT_W'(1)) begin
          remain <= '0;
          armed  <= 1'b0;
          expire <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_pkg::*;
#(
  parameter int WR_W       = 32,
  parameter int PRE_DIV    = 8,
  parameter int CHAR_TIMES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        mode_i,
  input  logic              cd_wr_i,
  input  logic              bdiv_wr_i,
  input  logic [WR_W-1:0]   wdata_i,
  input  logic              rx_byte_i,
  output logic              sample_tick_o,
  output logic              bit_tick_o,
  output logic [3:0]        frame_bits_o,
  output logic              timeout_o,
  output logic [15:0]       cd_o,
  output logic [7:0]        bdiv_o
);

  mode_t             mode;
  logic              restart;
  logic [CD_W-1:0]   cd_q;
  logic [BDIV_W-1:0] bdiv_q;
  logic [FRAME_W-1:0] frame_bits;

  assign mode = mode_t'(mode_i);

  baud_div_regs #(
    .WR_W   (WR_W),
    .CD_W   (CD_W),
    .BDIV_W (BDIV_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cd_wr   (cd_wr_i),
    .bdiv_wr (bdiv_wr_i),
    .wdata   (wdata_i),
    .cd_q    (cd_q),
    .bdiv_q  (bdiv_q),
    .restart (restart)
  );

  baud_tick_gen #(
    .CD_W    (CD_W),
    .BDIV_W  (BDIV_W),
    .PRE_DIV (PRE_DIV)
  ) u_ticks (
    .clk         (clk),
    .rst_n       (rst_n),
    .pre_en      (mode.pre_en),
    .restart     (restart),
    .cd          (cd_q),
    .bdiv        (bdiv_q),
    .sample_tick (sample_tick_o),
    .bit_tick    (bit_tick_o)
  );

  frame_fmt_dec u_fmt (
    .mode       (mode),
    .frame_bits (frame_bits)
  );

  rx_timeout #(
    .CHAR_TIMES (CHAR_TIMES),
    .FRAME_W    (FRAME_W),
    .MAX_FRAME  (MAX_FRAME)
  ) u_tmo (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_byte    (rx_byte_i),
    .bit_tick   (bit_tick_o),
    .frame_bits (frame_bits),
    .expire     (timeout_o)
  );

  assign frame_bits_o = frame_bits;
  assign cd_o         = cd_q;
  assign bdiv_o       = bdiv_q;

endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  mode_i,
  input logic        cd_wr_i,
  input logic        bdiv_wr_i,
  input logic [31:0] wdata_i,
  input logic        rx_byte_i,
  input logic        sample_tick_o,
  input logic        bit_tick_o,
  input logic [3:0]  frame_bits_o,
  input logic        timeout_o,
  input logic [15:0] cd_o,
  input logic [7:0]  bdiv_o
);

  // R5
  bit_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick_o |-> sample_tick_o);

  // R9
  timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  // R10
  rx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_i |=> !timeout_o);

  // R3
  cd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_wr_i && wdata_i[15:0] == 16'd0) |=> $stable(cd_o));

  // R3
  bdiv_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bdiv_wr_i && wdata_i[7:0] < 8'd4) |=> $stable(bdiv_o));

  // R2
  cd_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_wr_i && wdata_i[15:0] != 16'd0) |=> cd_o == $past(wdata_i[15:0]));

  // R6
  frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bits_o >= 4'd8 && frame_bits_o <= 4'd12);

  // R7
  shortest_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[2:1] == 2'd3 && mode_i[5] && mode_i[7:6] != 2'd2) |-> frame_bits_o == 4'd8);

endmodule

bind uart_baud_gen uart_baud_gen_chk u_chk (.*);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;

  localparam int CLK_P    = 10;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mode_i = 8'h00;
  logic        cd_wr_i = 1'b0;
  logic        bdiv_wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rx_byte_i = 1'b0;
  logic        sample_tick_o, bit_tick_o, timeout_o;
  logic [3:0]  frame_bits_o;
  logic [15:0] cd_o;
  logic [7:0]  bdiv_o;

  int checks = 0;
  int errors = 0;
  int wd_cnt = 0;

  uart_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cd_wr_i(cd_wr_i),
    .bdiv_wr_i(bdiv_wr_i), .wdata_i(wdata_i), .rx_byte_i(rx_byte_i),
    .sample_tick_o(sample_tick_o), .bit_tick_o(bit_tick_o),
    .frame_bits_o(frame_bits_o), .timeout_o(timeout_o),
    .cd_o(cd_o), .bdiv_o(bdiv_o)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    wd_cnt <= wd_cnt + 1;
    if (wd_cnt >= WD_LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", wd_cnt, WD_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cd(input logic [31:0] v);
    wdata_i = v; cd_wr_i = 1'b1;
    @(negedge clk);
    cd_wr_i = 1'b0;
  endtask

  task automatic wr_bdiv(input logic [31:0] v);
    wdata_i = v; bdiv_wr_i = 1'b1;
    @(negedge clk);
    bdiv_wr_i = 1'b0;
  endtask

  task automatic period(input bit use_bit, output int n);
    int guard = 0;
    while (!(use_bit ? bit_tick_o : sample_tick_o) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!(use_bit ? bit_tick_o : sample_tick_o) && n < 2000);
  endtask

  task automatic rx_pulse();
    rx_byte_i = 1'b1;
    @(negedge clk);
    rx_byte_i = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1 cd reset", cd_o, 16'h028B);
    chk("R1 bdiv reset", bdiv_o, 8'h0F);
    chk("R1 timeout low", timeout_o, 0);
  endtask

  task automatic test_trunc();
    wr_cd(32'hABCD_0123);
    chk("R2 cd low bits", cd_o, 16'h0123);
    wr_bdiv(32'h0000_1A07);
    chk("R2 bdiv low bits", bdiv_o, 8'h07);
  endtask

  task automatic test_reject();
    wr_cd(32'h5555_0000);
    chk("R3 cd zero ignored", cd_o, 16'h0123);
    wr_bdiv(32'h0000_0003);
    chk("R3 bdiv 3 ignored", bdiv_o, 8'h07);
    wr_bdiv(32'h0000_0203);
    chk("R3 bdiv trunc 3 ignored", bdiv_o, 8'h07);
    wr_bdiv(32'h0000_0004);
    chk("R3 bdiv 4 accepted", bdiv_o, 8'h04);
  endtask

  task automatic test_restart();
    int n = 1;
    mode_i = 8'h00;
    wr_cd(32'd3);
    while (!sample_tick_o && n < 50) begin
      @(negedge clk); n++;
    end
    chk("R11 first sample after write", n, 3);
  endtask

  task automatic test_sample_period();
    int n;
    mode_i = 8'h00;
    wr_cd(32'd3);
    period(1'b0, n);
    chk("R4 sample period no prescale", n, 3);
    mode_i = 8'h01;
    wr_cd(32'd2);
    period(1'b0, n);
    chk("R4 sample period prescale", n, 16);
    mode_i = 8'h00;
  endtask

  task automatic test_bit_period();
    int n;
    int s = 0;
    wr_cd(32'd2);
    wr_bdiv(32'd4);
    period(1'b1, n);
    chk("R5 bit period", n, 10);
    do begin
      @(negedge clk);
      if (sample_tick_o) s++;
    end while (!bit_tick_o);
    chk("R5 samples per bit", s, 5);
  endtask

  task automatic test_frame();
    mode_i = 8'h00; @(negedge clk);
    chk("R6 default 8 data even 1 stop", frame_bits_o, 11);
    mode_i = 8'hE6; @(negedge clk);
    chk("R6 R7 6 data no parity", frame_bits_o, 8);
    mode_i = 8'h8C; @(negedge clk);
    chk("R6 R8 7 data odd 2 stop", frame_bits_o, 11);
    mode_i = 8'h7A; @(negedge clk);
    chk("R7 R8 8 data none stop1", frame_bits_o, 10);
    mode_i = 8'h90; @(negedge clk);
    chk("R7 R8 space parity 2 stop", frame_bits_o, 12);
  endtask

  task automatic run_timeout(input string req, input int nbits);
    int cnt = 0;
    int early = 0;
    rx_pulse();
    while (cnt < nbits) begin
      if (timeout_o) early++;
      if (bit_tick_o) cnt++;
      if (cnt < nbits) @(negedge clk);
    end
    chk({req, " no early pulse"}, early, 0);
    @(negedge clk);
    chk({req, " pulse high"}, timeout_o, 1);
    @(negedge clk);
    chk({req, " pulse one cycle"}, timeout_o, 0);
  endtask

  task automatic test_timeout();
    mode_i = 8'hE6;
    wr_cd(32'h0001_0001);
    wr_bdiv(32'd4);
    run_timeout("R9", 32);
  endtask

  task automatic test_rx_restart();
    int cnt = 0;
    int seen = 0;
    mode_i = 8'hE6;
    rx_pulse();
    while (cnt < 20) begin
      if (bit_tick_o) cnt++;
      if (timeout_o) seen++;
      @(negedge clk);
    end
    run_timeout("R10", 32);
    chk("R10 no pulse before restart", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_trunc();
    test_reject();
    test_restart();
    test_sample_period();
    test_bit_period();
    test_frame();
    test_timeout();
    test_rx_restart();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule